// File: doc/BRIEF.md
# Cascadable Strobe-Addressed Buffer Memory

This block is a word buffer filled by an asynchronous write strobe on a front port. Each accepted strobe stores the data word at the current address, and the address counter then advances by one. The block drives several outputs:

- an acknowledge pulse for every accepted word;
- a `full_o` level that stays high while space remains;
- an overflow level that rises once the address reaches one of four selectable thresholds.

Several units can be chained into one deeper buffer. The `full_o` output of one unit drives the veto input of the next, and all units share the strobe and data lines. Only one unit accepts each word: the first one that still has space.

A host port reads the buffer word by word with address increment or decrement. It can also write with increment, read or load the address, and read or load a 2-bit port-mode register. The port-mode encoding is 00 off, 01 host, 10 reserved and 11 front. The front port may write only in mode 11, and host data access works only in mode 01. A sticky interrupt flag follows the overflow level when it is enabled.

The depth is the parameter `DEPTH`, a power of two. The default is 2048; 16384 gives thresholds 12288, 14336, 15360 and 15872. The front strobe and the veto input are synchronised to the clock. Strobe edges are detected after synchronisation, so a commit is several clocks behind the strobe's falling edge.

The front-port tracker has three states:

- `FS_IDLE`: wait for a synchronised rising strobe. Transition *arm* goes to `FS_HOLD` and latches the data word.
- `FS_HOLD`: wait for a synchronised falling strobe. Transition *release* goes to `FS_COMMIT`.
- `FS_COMMIT`: lasts one cycle, during which the write is accepted or refused. Transition *retire* always returns to `FS_IDLE`.

Top module: `strobe_buffer_mem`

## Requirements
- R1: After reset the address is 0 and `full_o` is 1. `ovf_o`, `ack_o`, `irq_o` and `host_rvalid_o` are 0. The port-mode register reads 00 and the interrupt enable is off.
- R2: In port mode 11, each strobe pulse that is not vetoed stores `wr_data_i` at the current address. The data is sampled while the strobe is high. The address then rises by one after the strobe's falling edge.
- R3: A strobe whose falling edge is seen while `veto_i` is high stores nothing and leaves the address unchanged. The next strobe without veto is stored again.
- R4: `full_o` is 1 while the address is below `DEPTH` and 0 once it equals `DEPTH`. The address never exceeds `DEPTH`, and strobes arriving at capacity store nothing.
- R5: `ack_o` gives exactly one one-cycle pulse for each accepted front write, ACK_DLY cycles after the commit. Refused strobes (vetoed, at capacity, or wrong port mode) give no pulse.
- R6: `ovf_o` is 1 while the address is at or above a threshold of DEPTH − DEPTH/2^(s+2), where s is the value of `thr_sel_i` (0..3).
- R7: Op 9 enables the interrupt and op 10 disables it.
  - While enabled and `ovf_o` is 1, `irq_o` sets and then stays set.
  - Op 11 (test-and-clear) answers q = the flag value and clears the flag.
  - While disabled, `irq_o` never sets.
- R8: A `clr_i` pulse or host op 8 (initialise) sets the address to 0 and clears `irq_o`.
- R9: Op 1 (read-increment), in mode 01 below capacity, returns the word at the address with q=1 and increments the address. At capacity it answers q=0, returns data 0 and leaves the address unchanged.
- R10: Op 2 (read-decrement), in mode 01, returns the word with q=1 and decrements the address. At address 0 it returns the word and keeps the address at 0, and every further op 2 answers q=0 until the address is changed. At capacity it returns 0 with q=1 and steps to DEPTH−1.
- R11: Op 3 (write-increment), in mode 01 below capacity, stores `host_wdata_i` and increments the address with q=1. At capacity it answers q=0 and stores nothing.
- R12: The other ops are always answered with q=1:
  - op 4 returns the address;
  - op 5 loads the address from the low log2(DEPTH) bits of `host_wdata_i`;
  - op 6 returns the port-mode register;
  - op 7 loads it from bits [1:0];
  - op 0 and undefined codes answer q=0.
- R13: Outside mode 01, ops 1, 2 and 3 answer q=0 and change neither the address nor the memory. Outside mode 11, front strobes store nothing.
- R14: Every host request is answered one cycle later. `host_rvalid_o` is 1 for that cycle, and `host_q_o` and `host_rdata_o` are valid during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_strobe_i | input | 1 | Asynchronous front write strobe, word stored after its falling edge |
| wr_data_i | input | DW | Front data word, stable while the strobe is high |
| veto_i | input | 1 | Blocks front strobes while high (chain input from previous `full_o`) |
| clr_i | input | 1 | Synchronous clear of address and interrupt flag |
| thr_sel_i | input | 2 | Overflow threshold select |
| host_valid_i | input | 1 | Host request strobe, one cycle |
| host_op_i | input | 4 | Host operation code |
| host_wdata_i | input | DW | Host write data / load value |
| host_rvalid_o | output | 1 | Host response valid |
| host_q_o | output | 1 | Host request was executed |
| host_rdata_o | output | DW | Host read data |
| full_o | output | 1 | Space remains (high while address below DEPTH) |
| ack_o | output | 1 | Delayed echo pulse of an accepted front write |
| ovf_o | output | 1 | Address at or above the selected threshold |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Most internal faults become visible at the ports within one host transaction.

- A wrong address counter shows on the next address-read response, and within one cycle on `full_o` and `ovf_o`.
- A tracker stuck in `FS_HOLD`, or committing twice, shows as a missing or extra acknowledge pulse within about a dozen clocks of the strobe's falling edge.
- A write to the wrong location shows only when the host reads that word back, so every stored word is read back by value.
- A mishandled boundary appears as a wrong q answer on the first refused request. The boundaries covered are the bottom flag of read-decrement and the capacity limit.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_RD_INC   = 4'd1,
        OP_RD_DEC   = 4'd2,
        OP_WR_INC   = 4'd3,
        OP_RD_ADDR  = 4'd4,
        OP_LD_ADDR  = 4'd5,
        OP_RD_PORT  = 4'd6,
        OP_LD_PORT  = 4'd7,
        OP_INIT     = 4'd8,
        OP_IRQ_EN   = 4'd9,
        OP_IRQ_DIS  = 4'd10,
        OP_IRQ_TCLR = 4'd11
    } host_op_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_HOLD   = 2'd1,
        FS_COMMIT = 2'd2
    } front_state_e;

    typedef enum logic [1:0] {
        PM_OFF   = 2'b00,
        PM_HOST  = 2'b01,
        PM_RSVD  = 2'b10,
        PM_FRONT = 2'b11
    } port_mode_e;

endpackage

// File: rtl/sbm_front_fsm.sv
module sbm_front_fsm
    import sbm_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          veto_i,
    input  logic [DW-1:0] data_i,
    output logic          commit_o,
    output logic          veto_s_o,
    output logic [DW-1:0] data_o
);

    logic [SYNC_STAGES-1:0] stb_sync;
    logic [SYNC_STAGES-1:0] vet_sync;
    logic                   stb_s;
    logic                   stb_prev;
    logic                   stb_rise;
    logic                   stb_fall;
    front_state_e           state_q;
    front_state_e           state_d;
    logic [DW-1:0]          word_q;

    // Two-or-more stage synchronisers for strobe and veto
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_sync <= '0;
            vet_sync <= '0;
            stb_prev <= 1'b0;
        end else begin
            stb_sync <= {stb_sync[SYNC_STAGES-2:0], strobe_i};
            vet_sync <= {vet_sync[SYNC_STAGES-2:0], veto_i};
            stb_prev <= stb_s;
        end
    end

    assign stb_s    = stb_sync[SYNC_STAGES-1];
    assign stb_rise = stb_s && !stb_prev;
    assign stb_fall = !stb_s && stb_prev;

    // Next-state logic: arm, release, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:   if (stb_rise) state_d = FS_HOLD;
            FS_HOLD:   if (stb_fall) state_d = FS_COMMIT;
            FS_COMMIT: state_d = FS_IDLE;
            default:   state_d = FS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Outputs: data latched on arm, commit pulse in FS_COMMIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           word_q <= '0;
        else if (state_q == FS_IDLE && stb_rise) word_q <= data_i;
    end

    assign commit_o = (state_q == FS_COMMIT);
    assign veto_s_o = vet_sync[SYNC_STAGES-1];
    assign data_o   = word_q;

    AST_COMMIT_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(state_q == FS_HOLD && !stb_s)) else $error("commit without release"); // R2

endmodule

// File: rtl/sbm_ack_delay.sv
module sbm_ack_delay #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic pulse_o
);

    logic [DLY-1:0] sr_q;

    generate
        if (DLY == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= pulse_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[DLY-2:0], pulse_i};
            end
        end
    endgenerate

    assign pulse_o = sr_q[DLY-1];

endmodule

// File: rtl/sbm_store.sv
module sbm_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/strobe_buffer_mem.sv
module strobe_buffer_mem
    import sbm_pkg::*;
#(
    parameter int DW          = 16,
    parameter int DEPTH       = 2048,
    parameter int ACK_DLY     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_strobe_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          veto_i,
    input  logic          clr_i,
    input  logic [1:0]    thr_sel_i,
    input  logic          host_valid_i,
    input  logic [3:0]    host_op_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic          host_rvalid_o,
    output logic          host_q_o,
    output logic [DW-1:0] host_rdata_o,
    output logic          full_o,
    output logic          ack_o,
    output logic          ovf_o,
    output logic          irq_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] THR0 = CW'(DEPTH - DEPTH / 4);
    localparam logic [CW-1:0] THR1 = CW'(DEPTH - DEPTH / 8);
    localparam logic [CW-1:0] THR2 = CW'(DEPTH - DEPTH / 16);
    localparam logic [CW-1:0] THR3 = CW'(DEPTH - DEPTH / 32);

    // Front port
    logic          fe_commit;
    logic          fe_veto;
    logic [DW-1:0] fe_data;
    logic          front_accept;

    // State
    logic [CW-1:0] addr_q, addr_d;
    logic [1:0]    port_q, port_d;
    logic          irq_en_q, irq_en_d;
    logic          irq_q, irq_clr;
    logic          bottom_q, bottom_d;
    logic          rvalid_q;
    logic          q_q, q_d;
    logic [DW-1:0] misc_q, misc_d;
    logic          sel_mem_q, sel_mem_d;

    // Memory access
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    logic          at_cap;
    logic          host_ok;
    logic [CW-1:0] thr;
    host_op_e      op;

    sbm_front_fsm #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (wr_strobe_i),
        .veto_i   (veto_i),
        .data_i   (wr_data_i),
        .commit_o (fe_commit),
        .veto_s_o (fe_veto),
        .data_o   (fe_data)
    );

    sbm_ack_delay #(.DLY(ACK_DLY)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (front_accept),
        .pulse_o (ack_o)
    );

    sbm_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_q[AW-1:0]),
        .rdata (mem_rdata)
    );

    // Threshold and level outputs
    always_comb begin
        unique case (thr_sel_i)
            2'd0:    thr = THR0;
            2'd1:    thr = THR1;
            2'd2:    thr = THR2;
            default: thr = THR3;
        endcase
    end

    assign at_cap  = (addr_q >= CAP);
    assign full_o  = !at_cap;
    assign ovf_o   = (addr_q >= thr);
    assign host_ok = (port_q == PM_HOST);
    assign op      = host_op_e'(host_op_i);

    assign front_accept = fe_commit && !fe_veto && (port_q == PM_FRONT) && !at_cap;

    // Host decode and address arbitration
    always_comb begin
        addr_d    = addr_q;
        port_d    = port_q;
        irq_en_d  = irq_en_q;
        irq_clr   = 1'b0;
        bottom_d  = bottom_q;
        q_d       = 1'b0;
        misc_d    = '0;
        sel_mem_d = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = addr_q[AW-1:0];
        mem_wdata = fe_data;

        if (front_accept) begin
            mem_we   = 1'b1;
            addr_d   = addr_q + CW'(1);
            bottom_d = 1'b0;
        end

        if (host_valid_i) begin
            unique case (op)
                OP_RD_INC: begin
                    if (host_ok && !at_cap) begin
                        q_d       = 1'b1;
                        sel_mem_d = 1'b1;
                        addr_d    = addr_q + CW'(1);
                        bottom_d  = 1'b0;
                    end
                end
                OP_RD_DEC: begin
                    if (host_ok && !bottom_q) begin
                        q_d       = 1'b1;
                        sel_mem_d = !at_cap;
                        if (addr_q == '0) bottom_d = 1'b1;
                        else              addr_d   = addr_q - CW'(1);
                    end
                end
                OP_WR_INC: begin
                    if (host_ok && !at_cap) begin
                        q_d       = 1'b1;
                        mem_we    = 1'b1;
                        mem_wdata = host_wdata_i;
                        addr_d    = addr_q + CW'(1);
                        bottom_d  = 1'b0;
                    end
                end
                OP_RD_ADDR: begin
                    q_d    = 1'b1;
                    misc_d = DW'(addr_q);
                end
                OP_LD_ADDR: begin
                    q_d      = 1'b1;
                    addr_d   = CW'(host_wdata_i[AW-1:0]);
                    bottom_d = 1'b0;
                end
                OP_RD_PORT: begin
                    q_d    = 1'b1;
                    misc_d = DW'(port_q);
                end
                OP_LD_PORT: begin
                    q_d    = 1'b1;
                    port_d = host_wdata_i[1:0];
                end
                OP_INIT: begin
                    q_d      = 1'b1;
                    addr_d   = '0;
                    irq_clr  = 1'b1;
                    bottom_d = 1'b0;
                end
                OP_IRQ_EN: begin
                    q_d      = 1'b1;
                    irq_en_d = 1'b1;
                end
                OP_IRQ_DIS: begin
                    q_d      = 1'b1;
                    irq_en_d = 1'b0;
                end
                OP_IRQ_TCLR: begin
                    q_d     = irq_q;
                    irq_clr = 1'b1;
                end
                default: q_d = 1'b0;
            endcase
        end

        if (clr_i) begin
            addr_d   = '0;
            irq_clr  = 1'b1;
            bottom_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            port_q    <= PM_OFF;
            irq_en_q  <= 1'b0;
            irq_q     <= 1'b0;
            bottom_q  <= 1'b0;
            rvalid_q  <= 1'b0;
            q_q       <= 1'b0;
            misc_q    <= '0;
            sel_mem_q <= 1'b0;
        end else begin
            addr_q    <= addr_d;
            port_q    <= port_d;
            irq_en_q  <= irq_en_d;
            bottom_q  <= bottom_d;
            rvalid_q  <= host_valid_i;
            q_q       <= q_d;
            misc_q    <= misc_d;
            sel_mem_q <= sel_mem_d;
            if (irq_clr)                irq_q <= 1'b0;
            else if (irq_en_q && ovf_o) irq_q <= 1'b1;
        end
    end

    assign host_rvalid_o = rvalid_q;
    assign host_q_o      = q_q;
    assign host_rdata_o  = sel_mem_q ? mem_rdata : misc_q;
    assign irq_o         = irq_q;

    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= CAP) else $error("address beyond capacity"); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !(host_valid_i && (host_op_i == OP_LD_ADDR || host_op_i == OP_INIT)))
        |=> (addr_q == $past(addr_q)) || (addr_q == $past(addr_q) + CW'(1))
            || (addr_q + CW'(1) == $past(addr_q))) else $error("address jumped"); // R2

    AST_VETO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_commit && fe_veto && !host_valid_i && !clr_i) |=> $stable(addr_q))
        else $error("vetoed strobe moved address"); // R3

    AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (addr_q == '0 && !irq_o)) else $error("clear ineffective"); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ovf_o && irq_en_q)) else $error("spurious interrupt"); // R7

    AST_HOST_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid_i && host_op_i == OP_WR_INC && port_q != PM_HOST) |=> (host_rvalid_o && !host_q_o))
        else $error("host write outside host mode"); // R13

endmodule

// File: tb/sim_strobe_buffer_mem.sv
`timescale 1ns/1ps
module sim_strobe_buffer_mem;

    localparam int DW      = 16;
    localparam int DEPTH   = 2048;
    localparam int ACK_DLY = 4;
    localparam int NVEC    = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_strobe_i = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic          veto_i = 1'b0;
    logic          clr_i = 1'b0;
    logic [1:0]    thr_sel_i = 2'd0;
    logic          host_valid_i = 1'b0;
    logic [3:0]    host_op_i = 4'd0;
    logic [DW-1:0] host_wdata_i = '0;
    logic          host_rvalid_o;
    logic          host_q_o;
    logic [DW-1:0] host_rdata_o;
    logic          full_o, ack_o, ovf_o, irq_o;

    int checks = 0;
    int fails  = 0;
    int ack_cnt = 0;

    always #10 clk = ~clk;

    strobe_buffer_mem #(.DW(DW), .DEPTH(DEPTH), .ACK_DLY(ACK_DLY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_strobe_i(wr_strobe_i), .wr_data_i(wr_data_i),
        .veto_i(veto_i), .clr_i(clr_i), .thr_sel_i(thr_sel_i), .host_valid_i(host_valid_i),
        .host_op_i(host_op_i), .host_wdata_i(host_wdata_i), .host_rvalid_o(host_rvalid_o),
        .host_q_o(host_q_o), .host_rdata_o(host_rdata_o), .full_o(full_o), .ack_o(ack_o),
        .ovf_o(ovf_o), .irq_o(irq_o)
    );

    always @(negedge clk) if (rst_n && ack_o) ack_cnt++;

    // {req id[41:38], op[37:34], wdata[33:18], exp_q[17], chk_rd[16], exp_rd[15:0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {4'd13, 4'd3, 16'h1111, 1'b0, 1'b0, 16'h0000},
        {4'd12, 4'd7, 16'h0001, 1'b1, 1'b0, 16'h0000},
        {4'd12, 4'd6, 16'h0000, 1'b1, 1'b1, 16'h0001},
        {4'd12, 4'd5, 16'h0005, 1'b1, 1'b0, 16'h0000},
        {4'd11, 4'd3, 16'hAAAA, 1'b1, 1'b0, 16'h0000},
        {4'd11, 4'd3, 16'hBBBB, 1'b1, 1'b0, 16'h0000},
        {4'd11, 4'd4, 16'h0000, 1'b1, 1'b1, 16'h0007},
        {4'd12, 4'd5, 16'h0005, 1'b1, 1'b0, 16'h0000},
        {4'd9,  4'd1, 16'h0000, 1'b1, 1'b1, 16'hAAAA},
        {4'd9,  4'd1, 16'h0000, 1'b1, 1'b1, 16'hBBBB},
        {4'd9,  4'd4, 16'h0000, 1'b1, 1'b1, 16'h0007},
        {4'd12, 4'd5, 16'h0006, 1'b1, 1'b0, 16'h0000},
        {4'd10, 4'd2, 16'h0000, 1'b1, 1'b1, 16'hBBBB},
        {4'd10, 4'd2, 16'h0000, 1'b1, 1'b1, 16'hAAAA},
        {4'd10, 4'd4, 16'h0000, 1'b1, 1'b1, 16'h0004},
        {4'd12, 4'd5, 16'h0000, 1'b1, 1'b0, 16'h0000},
        {4'd11, 4'd3, 16'h0C0C, 1'b1, 1'b0, 16'h0000},
        {4'd12, 4'd5, 16'h0000, 1'b1, 1'b0, 16'h0000},
        {4'd10, 4'd2, 16'h0000, 1'b1, 1'b1, 16'h0C0C},
        {4'd10, 4'd2, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {4'd10, 4'd4, 16'h0000, 1'b1, 1'b1, 16'h0000},
        {4'd12, 4'd7, 16'h0003, 1'b1, 1'b0, 16'h0000},
        {4'd13, 4'd3, 16'h2222, 1'b0, 1'b0, 16'h0000},
        {4'd13, 4'd4, 16'h0000, 1'b1, 1'b1, 16'h0000}
    };

    function automatic string req_name(input logic [3:0] id);
        case (id)
            4'd9:    return "R9";
            4'd10:   return "R10";
            4'd11:   return "R11";
            4'd12:   return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one host request at a negedge; returns at the negedge where the answer is valid
    task automatic host(input logic [3:0] op, input logic [15:0] wd);
        host_valid_i = 1'b1;
        host_op_i    = op;
        host_wdata_i = wd;
        @(negedge clk);
        host_valid_i = 1'b0;
        host_op_i    = 4'd0;
    endtask

    task automatic front_write(input logic [15:0] d);
        wr_data_i   = d;
        wr_strobe_i = 1'b1;
        repeat (4) @(negedge clk);
        wr_strobe_i = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(full_o == 1'b1, "R1 full", full_o, 1);
        check(ovf_o == 1'b0 && ack_o == 1'b0 && irq_o == 1'b0, "R1 levels",
              {ovf_o, ack_o, irq_o}, 0);
        check(host_rvalid_o == 1'b0, "R1 rvalid", host_rvalid_o, 0);
        host(4'd6, 16'h0);
        check(host_rvalid_o == 1'b1, "R14 rvalid", host_rvalid_o, 1);
        check(host_rdata_o == 16'h0, "R1 port mode", host_rdata_o, 0);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'h0, "R1 address", host_rdata_o, 0);

        // Vector table: host access paths
        for (int i = 0; i < NVEC; i++) begin
            host(VEC[i][37:34], VEC[i][33:18]);
            check(host_rvalid_o == 1'b1, "R14 table rvalid", host_rvalid_o, 1);
            check(host_q_o == VEC[i][17], req_name(VEC[i][41:38]), host_q_o, VEC[i][17]);
            if (VEC[i][16])
                check(host_rdata_o == VEC[i][15:0], req_name(VEC[i][41:38]), host_rdata_o, VEC[i][15:0]);
        end

        // R2 / R5: front writes in mode 11 (mode 11, address 0 here)
        a0 = ack_cnt;
        front_write(16'h1234);
        front_write(16'h5678);
        check(ack_cnt - a0 == 2, "R5 ack count", ack_cnt - a0, 2);
        host(4'd7, 16'h1);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'd2, "R2 address advance", host_rdata_o, 2);
        host(4'd5, 16'h0);
        host(4'd1, 16'h0);
        check(host_rdata_o == 16'h1234, "R2 word 0", host_rdata_o, 16'h1234);
        host(4'd1, 16'h0);
        check(host_rdata_o == 16'h5678, "R2 word 1", host_rdata_o, 16'h5678);

        // R13: front strobe in host mode ignored
        a0 = ack_cnt;
        front_write(16'h9999);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'd2, "R13 front in host mode", host_rdata_o, 2);
        check(ack_cnt == a0, "R5 no ack when refused", ack_cnt - a0, 0);

        // R3: veto
        host(4'd7, 16'h3);
        veto_i = 1'b1;
        repeat (3) @(negedge clk);
        a0 = ack_cnt;
        front_write(16'h7777);
        veto_i = 1'b0;
        repeat (3) @(negedge clk);
        check(ack_cnt == a0, "R3 vetoed ack", ack_cnt - a0, 0);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'd2, "R3 vetoed address", host_rdata_o, 2);
        front_write(16'h4444);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'd3, "R3 resume after veto", host_rdata_o, 3);
        host(4'd7, 16'h1);
        host(4'd5, 16'd2);
        host(4'd1, 16'h0);
        check(host_rdata_o == 16'h4444, "R2 word after veto", host_rdata_o, 16'h4444);

        // R4 / R5: fill to capacity
        host(4'd5, 16'(DEPTH - 3));
        host(4'd7, 16'h3);
        a0 = ack_cnt;
        for (int k = 0; k < 5; k++) front_write(16'hC000 + 16'(k));
        check(full_o == 1'b0, "R4 full at capacity", full_o, 0);
        check(ack_cnt - a0 == 3, "R5 acks up to capacity", ack_cnt - a0, 3);
        check(irq_o == 1'b0, "R7 disabled irq", irq_o, 0);
        host(4'd7, 16'h1);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'(DEPTH), "R4 address stops", host_rdata_o, DEPTH);
        host(4'd1, 16'h0);
        check(host_q_o == 1'b0, "R9 no q at capacity", host_q_o, 0);
        host(4'd3, 16'hDEAD);
        check(host_q_o == 1'b0, "R11 no q at capacity", host_q_o, 0);
        host(4'd2, 16'h0);
        check(host_q_o == 1'b1 && host_rdata_o == 16'h0, "R10 dec at capacity",
              {host_q_o, host_rdata_o}, 32'h10000);
        host(4'd2, 16'h0);
        check(host_rdata_o == 16'hC002, "R10 last word", host_rdata_o, 16'hC002);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'(DEPTH - 2), "R10 address after dec", host_rdata_o, DEPTH - 2);

        // R6: thresholds
        for (int s = 0; s < 4; s++) begin
            int thr;
            thr = DEPTH - (DEPTH >> (s + 2));
            thr_sel_i = 2'(s);
            host(4'd5, 16'(thr - 1));
            check(ovf_o == 1'b0, "R6 below threshold", ovf_o, 0);
            host(4'd5, 16'(thr));
            check(ovf_o == 1'b1, "R6 at threshold", ovf_o, 1);
        end

        // R7: interrupt
        thr_sel_i = 2'd0;
        host(4'd5, 16'(DEPTH - DEPTH / 4));
        host(4'd9, 16'h0);
        @(negedge clk);
        check(irq_o == 1'b1, "R7 irq sets", irq_o, 1);
        host(4'd5, 16'h0);
        @(negedge clk);
        check(irq_o == 1'b1, "R7 irq sticky", irq_o, 1);
        host(4'd11, 16'h0);
        check(host_q_o == 1'b1, "R7 test-clear q", host_q_o, 1);
        check(irq_o == 1'b0, "R7 cleared", irq_o, 0);
        host(4'd11, 16'h0);
        check(host_q_o == 1'b0, "R7 second test-clear", host_q_o, 0);

        // R8: clear input and initialise op
        host(4'd5, 16'd1600);
        repeat (2) @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check(irq_o == 1'b0, "R8 clr irq", irq_o, 0);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'h0, "R8 clr address", host_rdata_o, 0);
        host(4'd5, 16'd1700);
        repeat (2) @(negedge clk);
        check(irq_o == 1'b1, "R7 irq before init", irq_o, 1);
        host(4'd8, 16'h0);
        check(irq_o == 1'b0 && host_q_o == 1'b1, "R8 init", {irq_o, host_q_o}, 1);
        host(4'd4, 16'h0);
        check(host_rdata_o == 16'h0, "R8 init address", host_rdata_o, 0);
        host(4'd15, 16'h0);
        check(host_q_o == 1'b0, "R12 undefined op", host_q_o, 0);

        finish_run();
    end

endmodule